// File: doc/BRIEF.md
# Transmit Word-to-Byte Unpacker

This block sits at the transmit edge of a packet datapath. It takes packet data as 32-bit words with start, end, a 2-bit modulo field and an abort strobe, and turns them into a byte stream that a downstream line framer can consume one byte per cycle. Each byte leaves with start, end and abort markers, so the framer knows where a packet begins, where it closes, and whether to close it normally or with an abort sequence.

Words are written under an active-low write enable into a small word buffer. A space indication tells the writer when it may send. It drops while there is still margin for one more word, so a word already launched by a registered upstream stage is not lost. Bytes leave most significant first under a valid/ready handshake. If a new packet starts while the previous one was never closed, the unpacker inserts a single closing byte that marks the old packet as aborted.

Top module: `pkt_word_unpacker`

## Requirements
- R1: A word is taken only on a rising clock edge where `wr_en_n` is 0 and `space_ok` is 1. When `wr_en_n` is 1, all other write inputs (including `wr_sop` and `wr_err`) have no effect on the byte stream.
- R2: A taken word without `wr_eop` yields four bytes. The first byte comes from bits 31:24, then 23:16, 15:8 and 7:0.
- R3: A taken word with `wr_eop` yields 4 - `wr_mod` bytes, taken from the most significant byte downward: 00 gives bits 31:0, 01 gives 31:8, 10 gives 31:16 and 11 gives 31:24.
- R4: `wr_mod` has no effect on a word taken without `wr_eop`.
- R5: `wr_err` counts only on a taken word that also has `wr_eop`. The last byte of that packet then has `out_abort` = 1. On any other word `wr_err` is ignored. `out_abort` is only ever 1 together with `out_eop`.
- R6: The first byte of a word taken with `wr_sop` has `out_sop` = 1. The last valid byte of a word taken with `wr_eop` has `out_eop` = 1. All other bytes have both flags at 0.
- R7: A word taken with `wr_sop` while a packet is open (started and not yet ended) is preceded in the output by one extra byte of value 0x00 with `out_eop` = 1, `out_abort` = 1 and `out_sop` = 0.
- R8: A byte transfers on an edge where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, the output byte and its flags hold steady.
- R9: `space_ok` is 1 while at least 2 of the `DEPTH` buffer entries are free. With the output stalled from an empty state, exactly `DEPTH` words are taken (one of them is held in the output stage) before `space_ok` drops.
- R10: After a synchronous reset (`rst` = 1), the buffer is empty, no packet is open, `out_valid` is 0 and `space_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_n | input | 1 | Word write enable, active low |
| wr_data | input | 32 | Packet word, most significant byte first |
| wr_sop | input | 1 | Word starts a packet |
| wr_eop | input | 1 | Word ends a packet |
| wr_mod | input | 2 | Unused-byte count of the last word |
| wr_err | input | 1 | Abort the packet ending on this word |
| space_ok | output | 1 | Writer may send a word |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Consumer accepts the byte |
| out_byte | output | 8 | Output data byte |
| out_sop | output | 1 | Byte is the first of a packet |
| out_eop | output | 1 | Byte is the last of a packet |
| out_abort | output | 1 | Packet closes with an abort |

## Verification
The bench builds the block with its default `DEPTH` of 4. This depth is small enough that a stalled consumer fills the buffer within a few cycles, so the space threshold and the one-word margin can be reached directly. With four lanes, the bench sweeps every modulo value and every error setting over packets of one to three words. It runs each sweep with a free-flowing consumer and again with an irregular one. Garbage on disabled cycles and a restart of a packet that was never closed cover the cases where inputs must be ignored or must close a packet early.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;
    localparam int MOD_W  = $clog2(LANES);
    localparam int CNT_W  = $clog2(LANES + 1);

    // One buffered word with its packet context
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [CNT_W-1:0]  nbytes;
        logic              sop;
        logic              eop;
        logic              abort;
        logic              close_prev;
    } word_ent_t;

    // One output beat
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sop;
        logic              eop;
        logic              abort;
    } byte_beat_t;

    // Number of valid lanes in a final word, filled from the top lane down
    function automatic logic [CNT_W-1:0] lanes_from_mod(input logic [MOD_W-1:0] m);
        return CNT_W'(LANES) - CNT_W'(m);
    endfunction

    // Filler beat that closes a packet left open
    function automatic byte_beat_t close_beat();
        byte_beat_t b;
        b.data  = '0;
        b.sop   = 1'b0;
        b.eop   = 1'b1;
        b.abort = 1'b1;
        return b;
    endfunction

endpackage

// File: rtl/unpk_ingress.sv
module unpk_ingress
    import unpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_n,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [MOD_W-1:0]  wr_mod,
    input  logic              wr_err,
    input  logic              space_ok,
    output logic              push,
    output word_ent_t         push_ent
);

    logic open_q;

    assign push = !wr_en_n && space_ok;

    always_comb begin
        push_ent.data       = wr_data;
        push_ent.sop        = wr_sop;
        push_ent.eop        = wr_eop;
        push_ent.abort      = wr_err && wr_eop;
        push_ent.close_prev = wr_sop && open_q;
        push_ent.nbytes     = wr_eop ? lanes_from_mod(wr_mod) : CNT_W'(LANES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (push) begin
            if (wr_eop)
                open_q <= 1'b0;
            else if (wr_sop)
                open_q <= 1'b1;
        end
    end

    // R1
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_n |-> !push);

endmodule

// File: rtl/unpk_word_fifo.sv
module unpk_word_fifo
    import unpk_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int MARGIN = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  word_ent_t push_ent,
    input  logic      pop,
    output word_ent_t head_ent,
    output logic      empty,
    output logic      space_ok
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    word_ent_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [OCC_W-1:0] occ;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (occ == '0);
    assign space_ok = (occ + OCC_W'(MARGIN)) <= OCC_W'(DEPTH);
    assign head_ent = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push)
                wr_ptr <= bump(wr_ptr);
            if (pop)
                rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (occ < OCC_W'(DEPTH)));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/unpk_serializer.sv
module unpk_serializer
    import unpk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_empty,
    input  word_ent_t  head_ent,
    output logic       pop,
    input  logic       out_ready,
    output logic       out_valid,
    output byte_beat_t beat
);

    word_ent_t         cur_q;
    logic              cur_v;
    logic              close_q;
    logic [MOD_W-1:0]  idx_q;
    logic [BYTE_W-1:0] lane [LANES];
    logic              last_beat, fire, done;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane[g] = cur_q.data[WORD_W-1-g*BYTE_W -: BYTE_W];
        end
    endgenerate

    assign last_beat = !close_q && ((CNT_W'(idx_q) + 1'b1) == cur_q.nbytes);
    assign fire      = cur_v && out_ready;
    assign done      = fire && last_beat;
    assign pop       = !fifo_empty && (!cur_v || done);
    assign out_valid = cur_v;

    always_comb begin
        if (close_q) begin
            beat = close_beat();
        end else begin
            beat.data  = lane[idx_q];
            beat.sop   = cur_q.sop && (idx_q == '0);
            beat.eop   = cur_q.eop && last_beat;
            beat.abort = cur_q.abort && cur_q.eop && last_beat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_v   <= 1'b0;
            close_q <= 1'b0;
            idx_q   <= '0;
            cur_q   <= '0;
        end else if (pop) begin
            cur_q   <= head_ent;
            cur_v   <= 1'b1;
            close_q <= head_ent.close_prev;
            idx_q   <= '0;
        end else if (done) begin
            cur_v   <= 1'b0;
        end else if (fire) begin
            if (close_q)
                close_q <= 1'b0;
            else
                idx_q <= idx_q + 1'b1;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(out_valid) && !$past(out_ready))
            |-> (out_valid && $stable(beat)));

    // R5
    abort_with_eop_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && beat.abort) |-> beat.eop);

endmodule

// File: rtl/pkt_word_unpacker.sv
module pkt_word_unpacker
    import unpk_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_n,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [MOD_W-1:0]  wr_mod,
    input  logic              wr_err,
    output logic              space_ok,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_abort
);

    localparam int MARGIN = 2;

    logic       push, pop, fifo_empty;
    word_ent_t  push_ent, head_ent;
    byte_beat_t beat;

    unpk_ingress u_ingress (
        .clk      (clk),
        .rst      (rst),
        .wr_en_n  (wr_en_n),
        .wr_data  (wr_data),
        .wr_sop   (wr_sop),
        .wr_eop   (wr_eop),
        .wr_mod   (wr_mod),
        .wr_err   (wr_err),
        .space_ok (space_ok),
        .push     (push),
        .push_ent (push_ent)
    );

    unpk_word_fifo #(
        .DEPTH  (DEPTH),
        .MARGIN (MARGIN)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop),
        .head_ent (head_ent),
        .empty    (fifo_empty),
        .space_ok (space_ok)
    );

    unpk_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .head_ent   (head_ent),
        .pop        (pop),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .beat       (beat)
    );

    assign out_byte  = beat.data;
    assign out_sop   = beat.sop;
    assign out_eop   = beat.eop;
    assign out_abort = beat.abort;

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && space_ok));

endmodule

// File: tb/sim_pkt_word_unpacker.sv
module sim_pkt_word_unpacker;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en_n = 1'b1;
    logic [31:0] wr_data = '0;
    logic        wr_sop = 1'b0, wr_eop = 1'b0, wr_err = 1'b0;
    logic [1:0]  wr_mod = '0;
    logic        space_ok, out_valid, out_sop, out_eop, out_abort;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;

    int n_chk  = 0;
    int n_fail = 0;
    int rdy_mode = 0;
    int n_cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        open_m = 1'b0;
    logic [10:0] exp_q[$];

    pkt_word_unpacker #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_mod(wr_mod), .wr_err(wr_err),
        .space_ok(space_ok), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte), .out_sop(out_sop), .out_eop(out_eop),
        .out_abort(out_abort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > WATCHDOG) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", n_cyc, WATCHDOG);
            summary();
        end
    end

    // consumer ready pattern
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[0] | lfsr[3];
            default: out_ready = 1'b0;
        endcase
    end

    // output monitor: R2 R3 R6 R7 R5
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            logic [10:0] act, exp;
            act = {out_sop, out_eop, out_abort, out_byte};
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected byte: actual %h expected none", act);
            end else begin
                exp = exp_q.pop_front();
                if (act !== exp) begin
                    n_fail++;
                    $display("FAIL R2/R3/R5/R6/R7 byte {sop,eop,abort,data}: actual %h expected %h", act, exp);
                end
            end
        end
    end

    function automatic logic [31:0] mk_word(input int seed);
        logic [7:0] a;
        a = 8'(seed * 4 + 1);
        return {a, a + 8'd1, a + 8'd2, a + 8'd3};
    endfunction

    // expected model of one taken word
    task automatic model(input logic [31:0] d, input logic s, input logic e,
                         input logic [1:0] m, input logic er);
        int nb;
        if (s && open_m)
            exp_q.push_back({1'b0, 1'b1, 1'b1, 8'h00});   // R7
        nb = e ? 4 - int'(m) : 4;                         // R3 R4
        for (int i = 0; i < nb; i++)
            exp_q.push_back({s && i == 0, e && i == nb - 1, e && er && i == nb - 1,
                             d[31 - 8*i -: 8]});
        if (e) open_m = 1'b0;
        else if (s) open_m = 1'b1;
    endtask

    task automatic idle_garbage();
        wr_en_n = 1'b1;
        wr_sop  = lfsr[1];
        wr_eop  = lfsr[2];
        wr_err  = 1'b1;
        wr_mod  = lfsr[5:4];
        wr_data = {lfsr, lfsr};
    endtask

    task automatic put(input logic [31:0] d, input logic s, input logic e,
                       input logic [1:0] m, input logic er);
        forever begin
            @(posedge clk); #1;
            if (space_ok) break;
            idle_garbage();
        end
        wr_en_n = 1'b0; wr_data = d; wr_sop = s; wr_eop = e; wr_mod = m; wr_err = er;
        model(d, s, e, m, er);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            idle_garbage();
        end
    endtask

    task automatic drain();
        int t;
        t = 0;
        idle(1);
        while ((exp_q.size() != 0 || out_valid) && t < 2000) begin
            @(posedge clk); #1; idle_garbage(); t++;
        end
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2/R3 missing bytes: actual %0d left expected 0", exp_q.size());
        end
    endtask

    initial begin
        int seed;
        int taken;
        seed = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        n_chk++;   // R10
        if (out_valid !== 1'b0 || space_ok !== 1'b1) begin
            n_fail++;
            $display("FAIL R10 reset: actual valid %b space %b expected 0 1", out_valid, space_ok);
        end

        // sweep: length x mod x err, two consumer patterns (R2 R3 R4 R5 R6)
        for (int mode = 0; mode < 2; mode++) begin
            rdy_mode = mode;
            for (int len = 1; len <= 3; len++)
                for (int m = 0; m < 4; m++)
                    for (int er = 0; er < 2; er++) begin
                        for (int w = 0; w < len; w++) begin
                            put(mk_word(seed), w == 0, w == len - 1,
                                (w == len - 1) ? 2'(m) : 2'(3 - m),   // R4 mod on middle words
                                1'(er));                               // R5 err on middle words
                            seed++;
                        end
                        if ((seed & 1) == 0) idle(2);   // R1 garbage while disabled
                    end
            drain();
        end

        // R7: restart a packet that was never closed
        rdy_mode = 1;
        put(mk_word(seed), 1'b1, 1'b0, 2'd2, 1'b1); seed++;
        put(mk_word(seed), 1'b1, 1'b0, 2'd0, 1'b0); seed++;
        put(mk_word(seed), 1'b1, 1'b1, 2'd3, 1'b0); seed++;
        put(mk_word(seed), 1'b0, 1'b1, 2'd1, 1'b1); seed++;
        drain();

        // R9: fill with consumer stalled
        rdy_mode = 2;
        idle(2);
        taken = 0;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk); #1;
            if (space_ok) begin
                wr_en_n = 1'b0; wr_data = mk_word(seed); wr_sop = (taken == 0);
                wr_eop = 1'b0; wr_mod = 2'd1; wr_err = 1'b0;
                model(wr_data, wr_sop, 1'b0, 2'd1, 1'b0);
                seed++; taken++;
            end else begin
                idle_garbage();
            end
        end
        n_chk++;
        if (taken != DEPTH) begin
            n_fail++;
            $display("FAIL R9 words taken while stalled: actual %0d expected %0d", taken, DEPTH);
        end
        n_chk++;
        if (space_ok !== 1'b0 || out_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 full state: actual space %b valid %b expected 0 1", space_ok, out_valid);
        end
        rdy_mode = 0;
        put(mk_word(seed), 1'b0, 1'b1, 2'd0, 1'b0); seed++;
        drain();

        // R10: reset mid-packet clears the open state and the buffer
        rdy_mode = 2;
        put(mk_word(seed), 1'b1, 1'b0, 2'd0, 1'b0); seed++;
        idle(2);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        exp_q.delete();
        open_m = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || space_ok !== 1'b1) begin
            n_fail++;
            $display("FAIL R10 reset mid-packet: actual valid %b space %b expected 0 1", out_valid, space_ok);
        end
        rdy_mode = 0;
        put(mk_word(seed), 1'b1, 1'b1, 2'd2, 1'b0); seed++;   // no close byte expected
        drain();

        summary();
    end

endmodule